// File: doc/BRIEF.md
# Eight-Source Two-Level Interrupt Controller

This block gathers interrupt requests from eight sources and presents one winner to a processor core as a request line and a vector address. Four sources are external active-low pins: two main ones and two extra ones. Three come from timer overflows and one from a serial port flag. Software sets a global enable, a per-source enable and a one-bit priority for every source. The external sources can be set to falling-edge or low-level triggering.

Arbitration runs once per machine cycle, when the core pulses `cyc_en`. Within each of the two priority levels the sources are polled in a fixed order. The core answers a raised request with `vec_ack` and ends the service routine with `ret_strobe`. The controller keeps an in-service bit for each level. With these bits a high-level source can interrupt a low-level routine, and no other nesting is allowed.

Top module: `irq_ctrl_top`

## Requirements
- R1: After a synchronous reset `irq_req`, `irq_vec`, `xsrc_q`, `xtrg_q`, `tmr_flag_q` and `lvl_busy` are all zero.
- R2: Source index i gets vector 03h + 8*i. The polling order, index 0 first, is ext0, timer0, ext1, timer1, serial, timer2, ext2, ext3. Within a level the lowest index wins.
- R3: A source can win only while enable bit 7 is set and its own enable is set. The enable register uses bit 0 for ext0, bit 1 for timer0, bit 2 for ext1, bit 3 for timer1, bit 4 for serial and bit 5 for timer2. Bit 2 of the extra register enables ext2 and bit 6 enables ext3.
- R4: A priority bit of 1 puts a source in the high level. The priority register uses the same bit positions as the enable register, and the extra register uses bit 3 for ext2 and bit 7 for ext3. Any high-level request beats every low-level request.
- R5: The extra register is laid out, bit 7 down to bit 0, as: ext3 priority, ext3 enable, ext3 flag, ext3 type, ext2 priority, ext2 enable, ext2 flag, ext2 type. It reads back on `xsrc_q`.
- R6: The trigger register `xtrg_q` holds bit 0 = ext0 type, bit 1 = ext0 flag, bit 2 = ext1 type and bit 3 = ext1 flag. A type of 1 latches the flag on a synchronised falling edge. A type of 0 requests while the synchronised pin is low and latches no flag.
- R7: Acknowledging a source clears its edge flag, or its timer0/timer1 overflow flag. The timer2 and serial requests are level inputs and the controller does not clear them.
- R8: A `tmr0_ovf` or `tmr1_ovf` pulse sets `tmr_flag_q[0]` or `tmr_flag_q[1]`.
- R9: No request is raised while the high level is in service. While only the low level is in service, only high-level sources can win.
- R10: `ret_strobe` clears the high in-service bit if it is set, and otherwise clears the low one.
- R11: Arbitration updates `irq_req` and `irq_vec` only on `cyc_en`. `irq_req` falls the cycle after an acknowledge, and `irq_vec` holds until the next evaluation.
- R12: `vec_ack` while `irq_req` is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Machine-cycle enable; arbitration runs on it |
| en_wr | input | 1 | Write strobe, enable register |
| en_wdata | input | 8 | Enable register data |
| pri_wr | input | 1 | Write strobe, priority register |
| pri_wdata | input | 8 | Priority register data (bits 5:0 used) |
| xsrc_wr | input | 1 | Write strobe, extra-source register |
| xsrc_wdata | input | 8 | Extra-source register data |
| xtrg_wr | input | 1 | Write strobe, ext0/ext1 trigger register |
| xtrg_wdata | input | 4 | Trigger register data |
| ext_n | input | 4 | Asynchronous active-low pins: ext0, ext1, ext2, ext3 |
| tmr0_ovf | input | 1 | Timer0 overflow pulse |
| tmr1_ovf | input | 1 | Timer1 overflow pulse |
| tmr2_flag | input | 1 | Timer2 request level |
| uart_flag | input | 1 | Serial request level |
| vec_ack | input | 1 | Vector acknowledge strobe |
| ret_strobe | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 8 | Vector address of the winner |
| xsrc_q | output | 8 | Extra-source register readback |
| xtrg_q | output | 4 | Trigger register readback |
| tmr_flag_q | output | 2 | Timer0/timer1 overflow flags |
| lvl_busy | output | 2 | In-service bits: bit 1 high level, bit 0 low level |

## Verification
A falling edge on a pin passes two synchroniser flops and sets the edge flag on the third clock edge. A level request is seen after two edges. The winner appears on `irq_req`/`irq_vec` at the first `cyc_en` edge after that. The bench therefore waits five edges after a pin change and three after a timer pulse before it samples. The flag clear, the in-service set and the drop of `irq_req` after `vec_ack`, and the in-service clear after `ret_strobe`, all take effect on the very next edge, and the bench checks them one cycle after the strobe. Every sample is taken on the falling clock edge.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NSRC = 8;
  localparam int IDX_W = $clog2(NSRC);

  typedef enum logic [IDX_W-1:0] {
    SRC_EXT0 = 3'd0, SRC_TMR0 = 3'd1, SRC_EXT1 = 3'd2, SRC_TMR1 = 3'd3,
    SRC_UART = 3'd4, SRC_TMR2 = 3'd5, SRC_EXT2 = 3'd6, SRC_EXT3 = 3'd7
  } src_e;

  // lowest set index of a request mask (index 0 polls first)
  function automatic logic [IDX_W-1:0] first_set(input logic [NSRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic low,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], pin_n};
      last  <= chain[STAGES-1];
    end
  end

  assign low  = ~chain[STAGES-1];
  assign fall = last & ~chain[STAGES-1];
endmodule

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import irq_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en_wr,
  input  logic [7:0]       en_wdata,
  input  logic             pri_wr,
  input  logic [7:0]       pri_wdata,
  input  logic             xsrc_wr,
  input  logic [7:0]       xsrc_wdata,
  input  logic             xtrg_wr,
  input  logic [3:0]       xtrg_wdata,
  input  logic [3:0]       pin_low,
  input  logic [3:0]       pin_fall,
  input  logic             tmr0_ovf,
  input  logic             tmr1_ovf,
  input  logic             tmr2_flag,
  input  logic             uart_flag,
  input  logic             clr_vld,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [7:0]       ie_q,
  output logic [7:0]       xsrc_q,
  output logic [3:0]       xtrg_q,
  output logic [1:0]       tf_q,
  output logic [NSRC-1:0]  req_m,
  output logic [NSRC-1:0]  pri
);
  logic [5:0] ip_q;
  logic [7:0] xsrc_d;
  logic [3:0] xtrg_d;
  logic [1:0] tf_d;
  logic [NSRC-1:0] req, en;

  function automatic logic hit(input logic v, input logic [IDX_W-1:0] i, input src_e s);
    return v && (i == s);
  endfunction

  always_comb begin
    xtrg_d = xtrg_wr ? xtrg_wdata : xtrg_q;
    xsrc_d = xsrc_wr ? xsrc_wdata : xsrc_q;
    tf_d   = tf_q;
    if (hit(clr_vld, clr_idx, SRC_EXT0)) xtrg_d[1] = 1'b0;
    if (hit(clr_vld, clr_idx, SRC_EXT1)) xtrg_d[3] = 1'b0;
    if (hit(clr_vld, clr_idx, SRC_EXT2)) xsrc_d[1] = 1'b0;
    if (hit(clr_vld, clr_idx, SRC_EXT3)) xsrc_d[5] = 1'b0;
    if (hit(clr_vld, clr_idx, SRC_TMR0)) tf_d[0]   = 1'b0;
    if (hit(clr_vld, clr_idx, SRC_TMR1)) tf_d[1]   = 1'b0;
    if (xtrg_q[0] && pin_fall[0]) xtrg_d[1] = 1'b1;
    if (xtrg_q[2] && pin_fall[1]) xtrg_d[3] = 1'b1;
    if (xsrc_q[0] && pin_fall[2]) xsrc_d[1] = 1'b1;
    if (xsrc_q[4] && pin_fall[3]) xsrc_d[5] = 1'b1;
    if (tmr0_ovf) tf_d[0] = 1'b1;
    if (tmr1_ovf) tf_d[1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= '0;
      ip_q   <= '0;
      xsrc_q <= '0;
      xtrg_q <= '0;
      tf_q   <= '0;
    end else begin
      if (en_wr)  ie_q <= en_wdata;
      if (pri_wr) ip_q <= pri_wdata[5:0];
      xsrc_q <= xsrc_d;
      xtrg_q <= xtrg_d;
      tf_q   <= tf_d;
    end
  end

  always_comb begin
    req[SRC_EXT0] = xtrg_q[0] ? xtrg_q[1] : pin_low[0];
    req[SRC_TMR0] = tf_q[0];
    req[SRC_EXT1] = xtrg_q[2] ? xtrg_q[3] : pin_low[1];
    req[SRC_TMR1] = tf_q[1];
    req[SRC_UART] = uart_flag;
    req[SRC_TMR2] = tmr2_flag;
    req[SRC_EXT2] = xsrc_q[0] ? xsrc_q[1] : pin_low[2];
    req[SRC_EXT3] = xsrc_q[4] ? xsrc_q[5] : pin_low[3];
  end

  assign en    = {xsrc_q[6], xsrc_q[2], ie_q[5:0]};
  assign pri   = {xsrc_q[7], xsrc_q[3], ip_q};
  assign req_m = req & en & {NSRC{ie_q[7]}};
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ctrl_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_en,
  input  logic             ack,
  input  logic             reti,
  input  logic [NSRC-1:0]  req_m,
  input  logic [NSRC-1:0]  pri,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic [IDX_W-1:0] sel_idx,
  output logic             grant,
  output logic [1:0]       busy
);
  logic [NSRC-1:0]  hi_m, lo_m;
  logic             found, pick_lvl, sel_lvl;
  logic [IDX_W-1:0] pick_idx;
  logic [1:0]       busy_d;

  assign hi_m  = req_m & pri;
  assign lo_m  = req_m & ~pri;
  assign grant = ack & irq_req;

  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    pick_lvl = 1'b0;
    if (!busy[1]) begin
      if (|hi_m) begin
        found    = 1'b1;
        pick_idx = first_set(hi_m);
        pick_lvl = 1'b1;
      end else if (!busy[0] && |lo_m) begin
        found    = 1'b1;
        pick_idx = first_set(lo_m);
      end
    end
  end

  always_comb begin
    busy_d = busy;
    if (reti) begin
      if (busy[1]) busy_d[1] = 1'b0;
      else         busy_d[0] = 1'b0;
    end
    if (grant) busy_d[sel_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      sel_idx <= '0;
      sel_lvl <= 1'b0;
      busy    <= '0;
    end else begin
      busy <= busy_d;
      if (grant) begin
        irq_req <= 1'b0;
      end else if (cyc_en) begin
        irq_req <= found;
        if (found) begin
          irq_vec <= VEC_W'(VEC_BASE + VEC_STEP * int'(pick_idx));
          sel_idx <= pick_idx;
          sel_lvl <= pick_lvl;
        end
      end
    end
  end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = 8,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STEP    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_en,
  input  logic             en_wr,
  input  logic [7:0]       en_wdata,
  input  logic             pri_wr,
  input  logic [7:0]       pri_wdata,
  input  logic             xsrc_wr,
  input  logic [7:0]       xsrc_wdata,
  input  logic             xtrg_wr,
  input  logic [3:0]       xtrg_wdata,
  input  logic [3:0]       ext_n,
  input  logic             tmr0_ovf,
  input  logic             tmr1_ovf,
  input  logic             tmr2_flag,
  input  logic             uart_flag,
  input  logic             vec_ack,
  input  logic             ret_strobe,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic [7:0]       xsrc_q,
  output logic [3:0]       xtrg_q,
  output logic [1:0]       tmr_flag_q,
  output logic [1:0]       lvl_busy
);
  localparam int NPIN = 4;

  logic [NPIN-1:0]  pin_low, pin_fall;
  logic [7:0]       ie_q;
  logic [NSRC-1:0]  req_m, pri;
  logic [IDX_W-1:0] sel_idx;
  logic             grant;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    irq_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst(rst), .pin_n(ext_n[g]), .low(pin_low[g]), .fall(pin_fall[g])
    );
  end

  irq_src_regs regs_i (
    .clk(clk), .rst(rst),
    .en_wr(en_wr), .en_wdata(en_wdata), .pri_wr(pri_wr), .pri_wdata(pri_wdata),
    .xsrc_wr(xsrc_wr), .xsrc_wdata(xsrc_wdata), .xtrg_wr(xtrg_wr), .xtrg_wdata(xtrg_wdata),
    .pin_low(pin_low), .pin_fall(pin_fall),
    .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .tmr2_flag(tmr2_flag), .uart_flag(uart_flag),
    .clr_vld(grant), .clr_idx(sel_idx),
    .ie_q(ie_q), .xsrc_q(xsrc_q), .xtrg_q(xtrg_q), .tf_q(tmr_flag_q),
    .req_m(req_m), .pri(pri)
  );

  irq_arbiter #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) arb_i (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .ack(vec_ack), .reti(ret_strobe),
    .req_m(req_m), .pri(pri),
    .irq_req(irq_req), .irq_vec(irq_vec), .sel_idx(sel_idx), .grant(grant), .busy(lvl_busy)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_en,
  input logic             vec_ack,
  input logic             ret_strobe,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic [1:0]       lvl_busy,
  input logic [7:0]       ie_q
);
  // R2
  vec_form_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec[2:0] == 3'd3));

  // R3
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!ie_q[7] && cyc_en && !vec_ack) |=> !irq_req);

  // R9
  hi_block_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_busy[1] && cyc_en && !vec_ack) |=> !irq_req);

  // R10
  ret_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_strobe && !(vec_ack && irq_req) && lvl_busy != 2'b00)
      |=> ($countones(lvl_busy) == $countones($past(lvl_busy)) - 1));

  // R11
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_ack && irq_req) |=> !irq_req);

  // R11
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cyc_en |=> $stable(irq_vec));

  // R12
  stray_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_ack && !irq_req && !ret_strobe) |=> $stable(lvl_busy));
endmodule

bind irq_ctrl_top irq_ctrl_chk #(.VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst(rst), .cyc_en(cyc_en), .vec_ack(vec_ack), .ret_strobe(ret_strobe),
  .irq_req(irq_req), .irq_vec(irq_vec), .lvl_busy(lvl_busy), .ie_q(ie_q)
);

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NTBL = 10;
  // fields: en(8) pri(8) xsrc(8) ext_n(4) tmr2(1) uart(1) exp_req(1) exp_vec(8)
  localparam logic [38:0] TBL [NTBL] = '{
    {8'h00, 8'h00, 8'h00, 4'b0000, 1'b1, 1'b1, 1'b0, 8'h00},  // R3 global off
    {8'h85, 8'h00, 8'h00, 4'b1100, 1'b0, 1'b0, 1'b1, 8'h03},  // R2 ext0 before ext1
    {8'h84, 8'h00, 8'h00, 4'b1100, 1'b0, 1'b0, 1'b1, 8'h13},  // R3 ext0 disabled
    {8'h85, 8'h04, 8'h00, 4'b1100, 1'b0, 1'b0, 1'b1, 8'h13},  // R4 ext1 high
    {8'hB0, 8'h00, 8'h00, 4'b1111, 1'b1, 1'b1, 1'b1, 8'h23},  // R2 serial before timer2
    {8'hB0, 8'h20, 8'h00, 4'b1111, 1'b1, 1'b1, 1'b1, 8'h2B},  // R4 timer2 high
    {8'h80, 8'h00, 8'h44, 4'b0011, 1'b0, 1'b0, 1'b1, 8'h33},  // R3 ext2 via extra enable
    {8'h80, 8'h00, 8'hC4, 4'b0011, 1'b0, 1'b0, 1'b1, 8'h3B},  // R4 ext3 high via bit 7
    {8'h3F, 8'h00, 8'h44, 4'b0000, 1'b1, 1'b1, 1'b0, 8'h00},  // R3 bit 7 clear
    {8'hFF, 8'h00, 8'h44, 4'b0000, 1'b1, 1'b1, 1'b1, 8'h03}   // R2 all pending
  };

  logic clk = 1'b0, rst = 1'b1, cyc_en = 1'b1;
  logic en_wr = 0, pri_wr = 0, xsrc_wr = 0, xtrg_wr = 0;
  logic [7:0] en_wdata = 0, pri_wdata = 0, xsrc_wdata = 0;
  logic [3:0] xtrg_wdata = 0, ext_n = 4'hF;
  logic tmr0_ovf = 0, tmr1_ovf = 0, tmr2_flag = 0, uart_flag = 0, vec_ack = 0, ret_strobe = 0;
  logic irq_req;
  logic [7:0] irq_vec, xsrc_q;
  logic [3:0] xtrg_q;
  logic [1:0] tmr_flag_q, lvl_busy;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl_top dut_i (
    .clk(clk), .rst(rst), .cyc_en(cyc_en),
    .en_wr(en_wr), .en_wdata(en_wdata), .pri_wr(pri_wr), .pri_wdata(pri_wdata),
    .xsrc_wr(xsrc_wr), .xsrc_wdata(xsrc_wdata), .xtrg_wr(xtrg_wr), .xtrg_wdata(xtrg_wdata),
    .ext_n(ext_n), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .tmr2_flag(tmr2_flag),
    .uart_flag(uart_flag), .vec_ack(vec_ack), .ret_strobe(ret_strobe),
    .irq_req(irq_req), .irq_vec(irq_vec), .xsrc_q(xsrc_q), .xtrg_q(xtrg_q),
    .tmr_flag_q(tmr_flag_q), .lvl_busy(lvl_busy)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(2); rst = 1'b0; tick(1);
  endtask

  task automatic wr_en(input logic [7:0] d);
    en_wdata = d; en_wr = 1; tick(1); en_wr = 0;
  endtask
  task automatic wr_pri(input logic [7:0] d);
    pri_wdata = d; pri_wr = 1; tick(1); pri_wr = 0;
  endtask
  task automatic wr_xsrc(input logic [7:0] d);
    xsrc_wdata = d; xsrc_wr = 1; tick(1); xsrc_wr = 0;
  endtask
  task automatic wr_xtrg(input logic [3:0] d);
    xtrg_wdata = d; xtrg_wr = 1; tick(1); xtrg_wr = 0;
  endtask
  task automatic ack_pulse();
    vec_ack = 1; tick(1); vec_ack = 0;
  endtask
  task automatic ret_pulse();
    ret_strobe = 1; tick(1); ret_strobe = 0;
  endtask
  task automatic t0_pulse();
    tmr0_ovf = 1; tick(1); tmr0_ovf = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    tick(1);
    do_reset();
    // R1 reset state
    chk("R1 irq_req", irq_req, 0);
    chk("R1 irq_vec", irq_vec, 0);
    chk("R1 xsrc_q", xsrc_q, 0);
    chk("R1 xtrg_q", xtrg_q, 0);
    chk("R1 tmr_flag_q", tmr_flag_q, 0);
    chk("R1 lvl_busy", lvl_busy, 0);

    // table walk: level-mode arbitration cases
    for (int i = 0; i < NTBL; i++) begin
      wr_en(TBL[i][38:31]);
      wr_pri(TBL[i][30:23]);
      wr_xsrc(TBL[i][22:15]);
      ext_n = TBL[i][14:11];
      tmr2_flag = TBL[i][10];
      uart_flag = TBL[i][9];
      tick(5);
      chk($sformatf("R2/R3/R4 row%0d irq_req", i), irq_req, TBL[i][8]);
      if (TBL[i][8]) chk($sformatf("R2/R3/R4 row%0d irq_vec", i), irq_vec, TBL[i][7:0]);
    end

    ext_n = 4'hF; tmr2_flag = 0; uart_flag = 0;
    tick(3);
    do_reset();
    // R12 stray acknowledge
    ack_pulse();
    chk("R12 busy after stray ack", lvl_busy, 2'b00);
    chk("R12 irq_req after stray ack", irq_req, 0);

    // R6 edge mode on ext0
    wr_xtrg(4'b0001);
    wr_en(8'h81);
    tick(2);
    ext_n[0] = 1'b0;
    tick(5);
    chk("R6 edge flag latched", xtrg_q, 4'b0011);
    chk("R6 edge request", irq_req, 1);
    chk("R2 ext0 vector", irq_vec, 8'h03);
    ack_pulse();
    chk("R7 edge flag cleared", xtrg_q, 4'b0001);
    chk("R11 irq_req drops", irq_req, 0);
    chk("R9 low level busy", lvl_busy, 2'b01);
    tick(4);
    chk("R9 no re-request", irq_req, 0);

    // R6 level mode: pin still low, no flag latched; R9 blocks the same level
    wr_xtrg(4'b0000);
    tick(4);
    chk("R6 level no flag", xtrg_q, 4'b0000);
    chk("R9 same level blocked", irq_req, 0);

    // R8/R9 high-level timer0 preempts the low routine
    wr_pri(8'h02);
    wr_en(8'h83);
    t0_pulse();
    tick(3);
    chk("R8 timer0 flag set", tmr_flag_q, 2'b01);
    chk("R9 preempt request", irq_req, 1);
    chk("R2 timer0 vector", irq_vec, 8'h0B);
    ack_pulse();
    chk("R9 both levels busy", lvl_busy, 2'b11);
    chk("R7 timer0 flag cleared", tmr_flag_q, 2'b00);
    tick(3);
    chk("R9 high busy blocks", irq_req, 0);

    // R10 return order
    ret_pulse();
    chk("R10 high cleared first", lvl_busy, 2'b01);
    tick(3);
    chk("R9 low still busy", irq_req, 0);
    ret_pulse();
    chk("R10 low cleared", lvl_busy, 2'b00);
    tick(3);
    chk("R6 level request returns", irq_req, 1);
    chk("R2 level ext0 vector", irq_vec, 8'h03);

    // R11 evaluation only on cyc_en, vector held
    cyc_en = 0;
    ack_pulse();
    chk("R11 drop without cyc_en", irq_req, 0);
    chk("R11 vector held", irq_vec, 8'h03);
    ext_n[0] = 1'b1;
    t0_pulse();
    tick(3);
    chk("R11 no eval while idle", irq_req, 0);
    chk("R11 vector still held", irq_vec, 8'h03);
    cyc_en = 1;
    tick(2);
    chk("R11 eval resumes", irq_req, 1);
    chk("R11 new vector", irq_vec, 8'h0B);

    // R5 extra register edge flag on ext2
    ext_n = 4'hF;
    do_reset();
    wr_xsrc(8'h05);
    wr_en(8'h80);
    tick(3);
    ext_n[2] = 1'b0;
    tick(5);
    chk("R5 ext2 flag bit", xsrc_q, 8'h07);
    chk("R2 ext2 vector", irq_vec, 8'h33);
    ack_pulse();
    chk("R7 ext2 flag cleared", xsrc_q, 8'h05);

    finish_run();
  end
endmodule